// File: doc/BRIEF.md
# Digital Input Glitch Filter Bank

This block conditions a bank of 24 digital input lines. Each raw line first passes through a two-flop synchroniser. It then goes either straight to the output, or through a glitch filter that changes the reported level only after the new level has stayed put for a programmed time. A single filter time is shared by every line. A per-line enable bit selects whether that line is filtered or bypassed.

Software reaches the block through a byte-wide register port. Through it, software sets the filter time as a 20-bit count of 200 ns ticks, sets the per-line enables, issues commit and flush strobes, and reads back the conditioned line levels one byte at a time. The tick is produced locally by a prescaler that divides the system clock. The conditioned lines are also available as a parallel output for logic next to the block.

Top module: `dio_glitch_filter`

## Requirements
- R1: After reset, the conditioned outputs are all 0, the active filter time is 0 and every per-line enable is 0, so every line is bypassed until an enable is written.
- R2: A read returns on `rd_data` one clock after `addr` is presented. Offsets 0x00, 0x01 and 0x02 return conditioned lines 7..0, 15..8 and 23..16, with the lowest line in bit 0. Any offset without a defined read returns 0.
- R3: For a line whose enable bit is 0, a level applied on `din` appears on `lines_q` at the third rising clock edge after it is applied.
- R4: For an enabled line with active filter time N > 0, the output takes a new level only after the synchronised input has differed from the output for N consecutive ticks. A pulse that covers fewer than N ticks never reaches the output.
- R5: With an active filter time of 0, enabled lines follow the synchronised input with no hold requirement.
- R6: Byte writes to offsets 0x08, 0x09 and 0x0A (bits 7..0, 15..8 and 19..16 of the time) go to a shadow register only. A write to offset 0x07 with bit 0 set copies the shadow into the active filter time, and the active time changes at no other point.
- R7: A write to offset 0x07 with bit 1 set restarts the stability count of every line. Time already spent at a new level is discarded, and the full filter time must pass again.
- R8: Enable bits are written at offsets 0x0C, 0x0D and 0x0E, one bit per line: line k is bit k mod 8 of byte k/8. 1 selects filtering and 0 selects bypass, independently for each line.
- R9: Bits 7..4 of the byte at offset 0x0A have no effect on the filter time.
- R10: The tick is one clock wide and recurs every `TICK_DIV` clocks (200 ns at the default 200 MHz clock).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 24 | Raw asynchronous input lines |
| wr_en | input | 1 | Register write strobe, one clock per byte |
| addr | input | 5 | Register byte offset |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data for `addr` |
| lines_q | output | 24 | Registered conditioned line levels |

## Verification
The checker watches several rules on every cycle:
- The outputs and configuration are cleared by reset.
- Bypassed lines copy the input exactly three clocks later.
- An enabled line with a non-zero filter time moves only in the cycle that follows a tick.
- The active filter time changes only after a commit strobe.
- Ticks never come back to back.

Only the bench scenarios can show that pulses one tick short of the filter time are rejected while pulses of exactly the filter time get through. They also show that uncommitted shadow writes and the upper nibble of the top time byte leave filtering unchanged, that a flush discards time already counted, and that the byte and bit placement of enables and readback is correct.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int OFS_PORT0   = 0;
  localparam int OFS_STROBE  = 7;
  localparam int OFS_IVL0    = 8;
  localparam int OFS_EN0     = 12;
  localparam int STB_COMMIT  = 0;
  localparam int STB_FLUSH   = 1;
endpackage

// File: rtl/dgf_sync2.sv
module dgf_sync2 #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dgf_tick_gen.sv
module dgf_tick_gen #(
  parameter int DIV = 40
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dgf_lane.sv
module dgf_lane #(
  parameter int IVL_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             tick,
  input  logic [IVL_W-1:0] ivl,
  input  logic             raw,
  output logic             q
);
  logic [IVL_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= 1'b0;
      held <= '0;
    end else if (flush || (raw == q)) begin
      held <= '0;
    end else if (ivl == '0) begin
      q    <= raw;
      held <= '0;
    end else if (tick) begin
      if (held == ivl - 1'b1) begin
        q    <= raw;
        held <= '0;
      end else begin
        held <= held + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dio_glitch_filter.sv
module dio_glitch_filter
  import dgf_pkg::*;
#(
  parameter int N_LINES  = 24,
  parameter int IVL_W    = 20,
  parameter int TICK_DIV = 40,
  parameter int ADDR_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] din,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rd_data,
  output logic [N_LINES-1:0] lines_q
);
  localparam int LINE_BYTES = (N_LINES + 7) / 8;
  localparam int IVL_BYTES  = (IVL_W + 7) / 8;

  logic [N_LINES-1:0] raw_s;
  logic [N_LINES-1:0] filt;
  logic [N_LINES-1:0] en_q;
  logic [IVL_W-1:0]   shd_ivl;
  logic [IVL_W-1:0]   act_ivl;
  logic               tick;
  logic               stb_wr;
  logic               flush;

  assign stb_wr = wr_en && (addr == ADDR_W'(OFS_STROBE));
  assign flush  = stb_wr && wdata[STB_FLUSH];

  dgf_sync2 #(.W(N_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (raw_s)
  );

  dgf_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_lane
    dgf_lane #(.IVL_W(IVL_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .flush (flush),
      .tick  (tick),
      .ivl   (act_ivl),
      .raw   (raw_s[g]),
      .q     (filt[g])
    );
  end

  // Configuration registers: enables, shadow time, committed time.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      shd_ivl <= '0;
      act_ivl <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (addr == ADDR_W'(OFS_EN0 + b)) begin
          for (int i = 0; i < 8; i++) begin
            if (8 * b + i < N_LINES) en_q[8 * b + i] <= wdata[i];
          end
        end
      end
      for (int b = 0; b < IVL_BYTES; b++) begin
        if (addr == ADDR_W'(OFS_IVL0 + b)) begin
          for (int i = 0; i < 8; i++) begin
            if (8 * b + i < IVL_W) shd_ivl[8 * b + i] <= wdata[i];
          end
        end
      end
      if (stb_wr && wdata[STB_COMMIT]) act_ivl <= shd_ivl;
    end
  end

  // Registered conditioned outputs: filtered or bypassed per line.
  always_ff @(posedge clk) begin
    if (rst) lines_q <= '0;
    else     lines_q <= (en_q & filt) | (~en_q & raw_s);
  end

  // Registered byte readback of the conditioned lines.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (addr == ADDR_W'(OFS_PORT0 + b)) begin
          for (int i = 0; i < 8; i++) begin
            if (8 * b + i < N_LINES) rd_data[i] <= lines_q[8 * b + i];
          end
        end
      end
    end
  end
endmodule

// File: rtl/dgf_checker.sv
module dgf_checker
  import dgf_pkg::*;
#(
  parameter int N_LINES  = 24,
  parameter int IVL_W    = 20,
  parameter int TICK_DIV = 40,
  parameter int ADDR_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] din,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [7:0]         wdata,
  input logic [N_LINES-1:0] lines_q,
  input logic [N_LINES-1:0] en_q,
  input logic [IVL_W-1:0]   act_ivl,
  input logic               tick
);
  logic       prev_rst = 1'b0;
  logic [2:0] up_cnt   = 3'd0;

  always_ff @(posedge clk) begin
    prev_rst <= rst;
    if (rst)                 up_cnt <= 3'd0;
    else if (up_cnt != 3'd7) up_cnt <= up_cnt + 3'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    prev_rst |-> (lines_q == '0 && en_q == '0 && act_ivl == '0)); // R1

  AST_BYPASS_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (up_cnt >= 3'd4) |-> ((lines_q & ~$past(en_q)) == ($past(din, 3) & ~$past(en_q)))); // R3

  AST_FILTER_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ((up_cnt >= 3'd3) && ($past(act_ivl, 2) != '0) && !$past(tick, 2))
      |-> (((lines_q ^ $past(lines_q)) & $past(en_q) & $past(en_q, 2)) == '0)); // R4

  AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((up_cnt >= 3'd1) && (act_ivl != $past(act_ivl)))
      |-> $past(wr_en && (addr == ADDR_W'(OFS_STROBE)) && wdata[STB_COMMIT])); // R6

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ((TICK_DIV > 1) && tick) |=> !tick); // R10
endmodule

bind dio_glitch_filter dgf_checker #(
  .N_LINES(N_LINES), .IVL_W(IVL_W), .TICK_DIV(TICK_DIV), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .din(din), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .lines_q(lines_q), .en_q(en_q), .act_ivl(act_ivl), .tick(tick)
);

// File: tb/sim_dio_glitch_filter.sv
`timescale 1ns/1ps
module sim_dio_glitch_filter;
  localparam int N  = 24;
  localparam int D  = 4;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  din = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rd_data;
  logic [N-1:0]  lines_q;

  int n_chk  = 0;
  int n_fail = 0;
  logic         watch = 1'b0;
  logic [N-1:0] seen  = '0;
  logic [7:0]   rv;
  logic [N-1:0] sv;

  always #2.5 clk = ~clk;

  dio_glitch_filter #(.N_LINES(N), .IVL_W(20), .TICK_DIV(D), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .din(din), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .lines_q(lines_q)
  );

  always @(negedge clk) if (watch) seen <= seen | lines_q;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); addr = AW'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); addr = AW'(a);
    @(negedge clk); v = rd_data;
  endtask

  task automatic set_ivl(input int v);
    wr(8, v & 8'hFF); wr(9, (v >> 8) & 8'hFF); wr(10, (v >> 16) & 8'h0F); wr(7, 1);
  endtask

  task automatic set_en(input logic [N-1:0] m);
    wr(12, m[7:0]); wr(13, m[15:8]); wr(14, m[23:16]);
  endtask

  task automatic pulse(input logic [N-1:0] m, input int len, input int win, output logic [N-1:0] s);
    @(negedge clk); seen = '0; watch = 1'b1; din = m;
    repeat (len) @(negedge clk);
    din = '0;
    repeat (win) @(negedge clk);
    watch = 1'b0; s = seen;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state and R2 readback at zero
    chk(lines_q == '0, "R1 outputs after reset", 32'(lines_q), 0);
    for (int b = 0; b < 3; b++) begin
      rd(b, rv);
      chk(rv == 8'h00, "R1 R2 port byte after reset", 32'(rv), 0);
    end
    // R1 enables cleared: with a long filter time committed, a one-cycle pulse still passes
    set_ivl(4);
    pulse('1, 1, 12, sv);
    chk(sv == {N{1'b1}}, "R1 enables zero after reset", 32'(sv), 32'hFFFFFF);

    // R3 bypass latency: three edges
    @(negedge clk); din[3] = 1'b1;
    @(negedge clk); chk(lines_q[3] == 1'b0, "R3 edge 1", 32'(lines_q[3]), 0);
    @(negedge clk); chk(lines_q[3] == 1'b0, "R3 edge 2", 32'(lines_q[3]), 0);
    @(negedge clk); chk(lines_q[3] == 1'b1, "R3 edge 3", 32'(lines_q[3]), 1);
    din = '0; repeat (6) @(negedge clk);

    // R2 byte placement of readback
    din = 24'hA5C3F1; repeat (6) @(negedge clk);
    rd(0, rv); chk(rv == 8'hF1, "R2 offset 0x00", 32'(rv), 32'hF1);
    rd(1, rv); chk(rv == 8'hC3, "R2 offset 0x01", 32'(rv), 32'hC3);
    rd(2, rv); chk(rv == 8'hA5, "R2 offset 0x02", 32'(rv), 32'hA5);
    rd(5, rv); chk(rv == 8'h00, "R2 unmapped offset", 32'(rv), 0);
    din = '0; repeat (6) @(negedge clk);

    // R4 / R10 boundary sweep: N-1 ticks rejected, N ticks accepted
    for (int iv = 1; iv <= 4; iv++) begin
      logic [N-1:0] m;
      m = N'(1) << (iv * 5);
      set_en(m);
      set_ivl(iv);
      for (int k = iv - 1; k <= iv; k++) begin
        if (k > 0) begin
          pulse(m, k * D, 2 * iv * D + 12, sv);
          chk(sv == ((k >= iv) ? m : '0), "R4 R10 pulse vs filter time", 32'(sv), 32'((k >= iv) ? m : '0));
        end
      end
    end

    // R5 zero filter time passes enabled lines
    set_en('1); set_ivl(0);
    pulse('1, 1, 10, sv);
    chk(sv == {N{1'b1}}, "R5 zero time passes", 32'(sv), 32'hFFFFFF);

    // R6 shadow write without commit has no effect
    set_ivl(4);
    wr(8, 1); wr(9, 0); wr(10, 0);
    pulse(N'(1) << 2, D, 4 * D + 12, sv);
    chk(sv == '0, "R6 uncommitted shadow ignored", 32'(sv), 0);
    wr(7, 1);
    pulse(N'(1) << 2, D, 2 * D + 12, sv);
    chk(sv == (N'(1) << 2), "R6 committed shadow used", 32'(sv), 32'h4);

    // R9 upper nibble of top time byte ignored
    wr(8, 2); wr(9, 0); wr(10, 8'hF0); wr(7, 1);
    pulse(N'(1) << 17, D, 4 * D + 12, sv);
    chk(sv == '0, "R9 time 2 rejects one tick", 32'(sv), 0);
    pulse(N'(1) << 17, 2 * D, 4 * D + 12, sv);
    chk(sv == (N'(1) << 17), "R9 time 2 accepts two ticks", 32'(sv), 32'h20000);

    // R8 per-line enable: line 9 is bit 1 of offset 0x0D
    wr(12, 0); wr(13, 8'h02); wr(14, 0); set_ivl(3);
    pulse(N'(3) << 8, 1, 8 * D + 12, sv);
    chk(sv == (N'(1) << 8), "R8 only line 9 filtered", 32'(sv), 32'h100);
    pulse(N'(3) << 8, 3 * D, 8 * D + 12, sv);
    chk(sv == (N'(3) << 8), "R8 long pulse passes both", 32'(sv), 32'h300);

    // R7 flush discards counted time
    set_en('1); set_ivl(4);
    @(negedge clk); din[20] = 1'b1;
    repeat (2 * D) @(negedge clk);
    wr(7, 2);
    repeat (3 * D - 2) @(negedge clk);
    chk(lines_q[20] == 1'b0, "R7 flush restarts count", 32'(lines_q[20]), 0);
    repeat (2 * D + 2) @(negedge clk);
    chk(lines_q[20] == 1'b1, "R7 full time after flush", 32'(lines_q[20]), 1);
    din = '0; repeat (8 * D + 10) @(negedge clk);
    chk(lines_q == '0, "R7 line returns low", 32'(lines_q), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule